// File: doc/BRIEF.md
# Calibrated ADC Code to Voltage Converter

This block turns a raw 12-bit converter reading into a calibrated output voltage. It holds a fixed calibration curve of twelve (code, voltage) breakpoints that are not evenly spaced. For each request it finds the segment of the curve that holds the code, then draws a straight line between that segment's two end points to get the result.

A request is one start pulse with the code beside it. The block registers the code and finds the segment in one cycle. It then runs a restoring divider for a fixed number of cycles and returns the voltage with a single-cycle done pulse. The voltage is an unsigned integer in hundredths of a volt, so 1535 means 15.35 V.

Codes below the lowest breakpoint return the lowest voltage. Codes at or above the highest breakpoint return the highest voltage. Every conversion takes the same number of cycles, whatever the code.

Top module: `pwl_code_to_volt`

## Requirements
- R1: While reset is held and after it is released, `volt_o` reads 0 and `done_o` reads 0 until the first conversion completes.
- R2: A code below 18 (the lowest breakpoint) returns 9, which is 0.09 V.
- R3: A code of 2674 or above (the highest breakpoint) returns 1535, which is 15.35 V.
- R4: A code equal to any breakpoint returns that breakpoint's voltage exactly. The breakpoints are 18:9, 253:145, 496:286, 738:426, 978:566, 1220:706, 1462:846, 1705:985, 1947:1123, 2189:1261, 2432:1399 and 2674:1535.
- R5: For a code x with x_i < x < x_{i+1}, the result is y_i + floor((y_{i+1} − y_i)·(x − x_i) / (x_{i+1} − x_i)), with the division truncated.
- R6: `done_o` is high for exactly one cycle per conversion. `volt_o` changes only in a cycle in which `done_o` is high, and otherwise holds its value.
- R7: `done_o` rises 25 clock cycles after the edge that samples `start_i` high. This is CODE_W + VOLT_W + 2 cycles with the default widths.
- R8: While a conversion is in progress, a `start_i` pulse is ignored. It neither changes the pending result nor produces an extra done pulse. A start in the cycle where `done_o` is high is accepted.
- R9: Every value delivered with `done_o` lies between 9 and 1535 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe; a conversion begins when it is sampled high while the block is idle |
| code_i | input | 12 | Raw converter code, sampled with `start_i` |
| volt_o | output | 11 | Calibrated voltage in units of 0.01 V, valid with `done_o` |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The latency and pulse checks assume that `start_i` is a clean synchronous level. They also assume that a start arriving while a conversion runs is meant to be dropped, not queued. The bound checker tracks this itself by accepting a start only when it considers the block idle, or in the done cycle. The stimulus drives `start_i` and `code_i` only on falling edges, so they are stable at every sampling edge. Every start the bench raises is either accepted, or is deliberately placed mid-conversion to test that it is dropped.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  // number of calibration breakpoints
  localparam int PWL_N = 12;

  // breakpoint codes, ascending (segment search relies on this order)
  localparam int PWL_X [PWL_N] = '{18, 253, 496, 738, 978, 1220,
                                   1462, 1705, 1947, 2189, 2432, 2674};

  // matching voltages in units of 0.01 V
  localparam int PWL_Y [PWL_N] = '{9, 145, 286, 426, 566, 706,
                                   846, 985, 1123, 1261, 1399, 1535};

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRCH = 2'd1,
    ST_DIV  = 2'd2
  } pwl_state_e;

endpackage

// File: rtl/pwl_seg_select.sv
module pwl_seg_select
  import pwl_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int VOLT_W = 11
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [VOLT_W-1:0] base_o,
  output logic [VOLT_W-1:0] rise_o,
  output logic [CODE_W-1:0] offs_o,
  output logic [CODE_W-1:0] span_o
);

  localparam int SEG_W = $clog2(PWL_N);

  logic [SEG_W-1:0] seg;
  logic             below;
  logic             above;

  // last breakpoint not above the code; table is sorted
  always_comb begin
    seg = '0;
    for (int i = 0; i < PWL_N - 1; i++) begin
      if (code_i >= CODE_W'(PWL_X[i])) seg = SEG_W'(i);
    end
  end

  assign below = code_i <  CODE_W'(PWL_X[0]);
  assign above = code_i >= CODE_W'(PWL_X[PWL_N-1]);

  always_comb begin
    if (below) begin
      base_o = VOLT_W'(PWL_Y[0]);
      rise_o = '0;
      offs_o = '0;
      span_o = CODE_W'(1);
    end else if (above) begin
      base_o = VOLT_W'(PWL_Y[PWL_N-1]);
      rise_o = '0;
      offs_o = '0;
      span_o = CODE_W'(1);
    end else begin
      base_o = VOLT_W'(PWL_Y[int'(seg)]);
      rise_o = VOLT_W'(PWL_Y[int'(seg)+1] - PWL_Y[int'(seg)]);
      offs_o = code_i - CODE_W'(PWL_X[int'(seg)]);
      span_o = CODE_W'(PWL_X[int'(seg)+1] - PWL_X[int'(seg)]);
    end
  end

endmodule

// File: rtl/pwl_restoring_div.sv
module pwl_restoring_div #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             fin_o
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run_q, run_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [NUM_W-1:0] acc_q, acc_n;
  logic [DEN_W:0]   rem_q, rem_n;
  logic [DEN_W-1:0] den_q, den_n;
  logic             fin_q, fin_n;

  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             take;
  logic             last;

  assign shifted = {rem_q[DEN_W-1:0], acc_q[NUM_W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den_q};
  assign take    = ~trial[DEN_W+1];
  assign last    = run_q && (cnt_q == CNT_W'(NUM_W - 1));

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    acc_n = acc_q;
    rem_n = rem_q;
    den_n = den_q;
    fin_n = 1'b0;
    if (load_i) begin
      run_n = 1'b1;
      cnt_n = '0;
      acc_n = num_i;
      rem_n = '0;
      den_n = den_i;
    end else if (run_q) begin
      acc_n = {acc_q[NUM_W-2:0], take};
      rem_n = take ? trial[DEN_W:0] : shifted;
      cnt_n = cnt_q + CNT_W'(1);
      if (last) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      fin_q <= 1'b0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
      acc_q <= acc_n;
      rem_q <= rem_n;
      den_q <= den_n;
      fin_q <= fin_n;
    end
  end

  assign quo_o = acc_q;
  assign fin_o = fin_q;

endmodule

// File: rtl/pwl_code_to_volt.sv
module pwl_code_to_volt
  import pwl_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int VOLT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [VOLT_W-1:0] volt_o,
  output logic              done_o
);

  localparam int NUM_W = CODE_W + VOLT_W;

  pwl_state_e        state_q, state_n;
  logic [CODE_W-1:0] code_q;
  logic [VOLT_W-1:0] base_q;
  logic [VOLT_W-1:0] volt_q, volt_n;
  logic              done_q, done_n;

  logic              code_en;
  logic              base_en;
  logic              div_load;

  logic [VOLT_W-1:0] seg_base;
  logic [VOLT_W-1:0] seg_rise;
  logic [CODE_W-1:0] seg_offs;
  logic [CODE_W-1:0] seg_span;
  logic [NUM_W-1:0]  product;
  logic [NUM_W-1:0]  quo;
  logic              div_fin;

  pwl_seg_select #(
    .CODE_W (CODE_W),
    .VOLT_W (VOLT_W)
  ) u_seg (
    .code_i (code_q),
    .base_o (seg_base),
    .rise_o (seg_rise),
    .offs_o (seg_offs),
    .span_o (seg_span)
  );

  assign product = NUM_W'(seg_rise) * NUM_W'(seg_offs);

  pwl_restoring_div #(
    .NUM_W (NUM_W),
    .DEN_W (CODE_W)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (div_load),
    .num_i  (product),
    .den_i  (seg_span),
    .quo_o  (quo),
    .fin_o  (div_fin)
  );

  always_comb begin
    state_n  = state_q;
    volt_n   = volt_q;
    done_n   = 1'b0;
    code_en  = 1'b0;
    base_en  = 1'b0;
    div_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          code_en = 1'b1;
          state_n = ST_SRCH;
        end
      end
      ST_SRCH: begin
        base_en  = 1'b1;
        div_load = 1'b1;
        state_n  = ST_DIV;
      end
      ST_DIV: begin
        if (div_fin) begin
          volt_n  = base_q + quo[VOLT_W-1:0];
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      volt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      volt_q  <= volt_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      base_q <= '0;
    end else begin
      if (code_en) code_q <= code_i;
      if (base_en) base_q <= seg_base;
    end
  end

  assign volt_o = volt_q;
  assign done_o = done_q;

endmodule

// File: rtl/pwl_code_to_volt_chk.sv
module pwl_code_to_volt_chk #(
  parameter int CODE_W = 12,
  parameter int VOLT_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CODE_W-1:0] code_i,
  input logic [VOLT_W-1:0] volt_o,
  input logic              done_o
);

  localparam int LAT   = CODE_W + VOLT_W + 2;
  localparam int CNT_W = $clog2(LAT + 2);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  // independent model of when a conversion is outstanding (R7, R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && (!busy_q || done_o)) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != CNT_W'(LAT + 1)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_volt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(volt_o));

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_q && cnt_q == CNT_W'(LAT)));

  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !done_o);

  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (volt_o >= VOLT_W'(9) && volt_o <= VOLT_W'(1535)));

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_o != '0) |-> $past(done_o) || done_o || !$stable(volt_o) || (volt_o >= VOLT_W'(9)));

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_out: assert (done_o == 1'b0 && volt_o == '0);
    end
  end

endmodule

bind pwl_code_to_volt pwl_code_to_volt_chk #(
  .CODE_W (CODE_W),
  .VOLT_W (VOLT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .code_i  (code_i),
  .volt_o  (volt_o),
  .done_o  (done_o)
);

// File: tb/tb_pwl_code_to_volt.sv
`timescale 1ns/1ps
module tb_pwl_code_to_volt;

  localparam int CODE_W = 12;
  localparam int VOLT_W = 11;
  localparam int LAT    = CODE_W + VOLT_W + 2;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [CODE_W-1:0] code_i;
  logic [VOLT_W-1:0] volt_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;

  int bx [12] = '{18, 253, 496, 738, 978, 1220, 1462, 1705, 1947, 2189, 2432, 2674};
  int by [12] = '{9, 145, 286, 426, 566, 706, 846, 985, 1123, 1261, 1399, 1535};

  pwl_code_to_volt #(.CODE_W(CODE_W), .VOLT_W(VOLT_W)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .code_i  (code_i),
    .volt_o  (volt_o),
    .done_o  (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int expect_volt(input int x);
    if (x < bx[0])  return by[0];
    if (x >= bx[11]) return by[11];
    for (int i = 0; i < 11; i++) begin
      if (x >= bx[i] && x < bx[i+1])
        return by[i] + ((by[i+1] - by[i]) * (x - bx[i])) / (bx[i+1] - bx[i]);
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one conversion; returns result and cycles from sampling edge to done
  task automatic convert(input int code, output int volt, output int lat);
    @(negedge clk);
    code_i  = CODE_W'(code);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    volt = int'(volt_o);
  endtask

  task automatic conv_check(input int code, input string req);
    int v, l;
    convert(code, v, l);
    check(v == expect_volt(code), req, v, expect_volt(code));
    check(l == LAT, "R7", l, LAT);
    @(posedge clk);
    @(negedge clk);
    check(done_o == 1'b0, "R6", int'(done_o), 0);
    check(int'(volt_o) == v, "R6", int'(volt_o), v);
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    start_i = 1'b0;
    code_i  = '0;
    repeat (3) @(negedge clk);
    check(volt_o == '0 && done_o == 1'b0, "R1", int'(volt_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(volt_o == '0, "R1", int'(volt_o), 0);
    check(done_o == 1'b0, "R1", int'(done_o), 0);
  endtask

  task automatic t_below();
    conv_check(0, "R2");
    conv_check(17, "R2");
    check(expect_volt(5) == 9, "R2", expect_volt(5), 9);
  endtask

  task automatic t_above();
    conv_check(2674, "R3");
    conv_check(2675, "R3");
    conv_check(4095, "R3");
  endtask

  task automatic t_breakpoints();
    for (int k = 0; k < 12; k++) begin
      int v, l;
      convert(bx[k], v, l);
      check(v == by[k], "R4", v, by[k]);
    end
  endtask

  task automatic t_interior();
    int v, l;
    convert(300, v, l);            // 145 + 141*47/243 = 145 + 27
    check(v == 172, "R5", v, 172);
    convert(252, v, l);            // 9 + 136*234/235 = 9 + 135
    check(v == 144, "R5", v, 144);
    convert(2673, v, l);           // 1399 + 136*241/242 = 1399 + 135
    check(v == 1534, "R5", v, 1534);
    for (int c = 19; c < 4096; c += 53) conv_check(c, "R5");
  endtask

  task automatic t_busy_start();
    int l, v, extra;
    @(negedge clk);
    code_i  = CODE_W'(1000);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    l = 0;
    while (!done_o && l < 100) begin
      if (l == 5) begin
        code_i  = CODE_W'(4000);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk);
      l++;
      @(negedge clk);
    end
    start_i = 1'b0;
    v = int'(volt_o);
    check(v == expect_volt(1000), "R8", v, expect_volt(1000));
    check(l == LAT, "R8", l, LAT);
    extra = 0;
    for (int n = 0; n < LAT + 5; n++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check(extra == 0, "R8", extra, 0);
    check(int'(volt_o) == v, "R8", int'(volt_o), v);
  endtask

  task automatic t_back_to_back();
    int l, v;
    convert(500, v, l);
    // raise start in the done cycle: must be accepted
    code_i  = CODE_W'(2000);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    l = 0;
    while (!done_o && l < 100) begin
      @(posedge clk);
      l++;
      @(negedge clk);
    end
    check(int'(volt_o) == expect_volt(2000), "R8", int'(volt_o), expect_volt(2000));
    check(l == LAT, "R7", l, LAT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_below();
    t_above();
    t_breakpoints();
    t_interior();
    t_busy_start();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule